// File: doc/BRIEF.md
# Class-to-channel credit gate

This block sits on the transmit side of a fabric link that carries eight traffic classes. A run-time programmable table folds those classes onto a smaller set of virtual channels. Each channel has its own transmit credit counter, counted in 16-byte units. The link partner fills these counters through credit return strobes. A class that is asking to send presents a request line and the length of its head packet in units. The gate releases at most one packet per cycle. A packet is released only if its channel holds enough credit for the whole packet, so nothing is ever dropped for lack of room downstream.

Channels that can send are served in rotation. When a channel runs short of credit it is masked, and it stays masked until returns top it up. Waiting classes on the other channels keep moving in the same cycle, so bandwidth that one channel cannot use goes to the others. The mapping table can be rewritten while traffic flows. A rewrite is held back until a cycle in which nothing is granted, so a packet always leaves on the channel it was granted on. Credit returns beyond the counter's range saturate the counter and latch a per-channel error flag.

Top module: `cg_credit_gate`

## Requirements
- R1: After reset every channel's credit reads 0, every overflow flag reads 0, no grant is driven, and class c maps to channel c mod 4.
- R2: A grant (gnt_vld=1) names a class whose request is high and whose mapped channel holds at least that class's packet length in credit. gnt_vc equals the class's current table entry. Without any request there is no grant.
- R3: At the clock edge that ends a granted cycle, the granted channel's credit falls by the packet length. A return strobe adds ret_amt to channel ret_vc at the same edge. When both hit one channel in one cycle, the net of the two is applied.
- R4: If a return would push a 12-bit counter past 4095, the counter holds at 4095 and that channel's bit of cred_ovf (bit index = channel) rises. The bit stays high until reset.
- R5: A class whose channel has less credit than its packet length is not granted. In that same cycle, an eligible class on another channel is granted.
- R6: Eligible channels are served round-robin. After channel v is granted, the next grant goes to the first eligible channel in the order v+1, v+2, … (mod 4). The pointer after reset is channel 3, so channel 0 is tried first.
- R7: When several eligible classes share the chosen channel, the lowest-numbered one is granted.
- R8: A table write (map_wr, class map_wr_cls to channel map_wr_vc) takes effect at the end of the first cycle, counting the write cycle itself, with no grant. Until then it is held pending, and a newer write replaces a pending one. A packet granted in the meantime uses the old entry.
- R9: Whenever at least one requesting class's channel holds enough credit, a grant is made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_req | input | 8 | Per-class send request, bit c = class c |
| cls_len | input | 56 | Head packet length per class in 16-byte units, class c at [7c+6:7c] |
| ret_vld | input | 1 | Credit return strobe |
| ret_vc | input | 2 | Channel receiving the returned credit |
| ret_amt | input | 12 | Returned credit in units |
| map_wr | input | 1 | Mapping table write strobe |
| map_wr_cls | input | 3 | Class whose entry is written |
| map_wr_vc | input | 2 | New channel for that class |
| gnt_vld | output | 1 | A packet is released this cycle |
| gnt_cls | output | 3 | Class released |
| gnt_vc | output | 2 | Channel the packet is charged to |
| cred_lvl | output | 48 | Credit per channel, channel v at [12v+11:12v] |
| cred_ovf | output | 4 | Sticky overflow flag per channel |

## Verification
The grant is combinational from the requests, the lengths, the table and the credit levels. The bench changes inputs on the falling edge and samples the grant one nanosecond later, in the same cycle. Credit levels and overflow flags move one edge after the cycle that caused them. They are therefore compared at the next falling edge against a model that the bench advances at each rising edge. Table writes are modelled as landing one edge after the first grant-free cycle. Only after that does the bench expect a grant on the new channel.

// File: rtl/cg_pkg.sv
package cg_pkg;

    localparam int CG_CLASSES  = 8;
    localparam int CG_CHANNELS = 4;
    localparam int CG_CRED_W   = 12;
    localparam int CG_LEN_W    = 7;
    localparam int CG_MAX_CH   = 16;

    typedef enum logic [0:0] {
        TBL_IDLE    = 1'b0,
        TBL_PENDING = 1'b1
    } tbl_state_e;

    // First set bit strictly after position last, scanning cyclically over n bits.
    function automatic int rr_first(input logic [CG_MAX_CH-1:0] elig,
                                    input int last, input int n);
        int idx;
        rr_first = -1;
        for (int i = 1; i <= CG_MAX_CH; i++) begin
            if (i <= n && rr_first < 0) begin
                idx = (last + i) % n;
                if (elig[idx]) rr_first = idx;
            end
        end
    endfunction

endpackage

// File: rtl/cg_map_table.sv
module cg_map_table
    import cg_pkg::*;
#(
    parameter int NUM_CLS = CG_CLASSES,
    parameter int NUM_VC  = CG_CHANNELS,
    localparam int CLS_W  = $clog2(NUM_CLS),
    localparam int VC_W   = $clog2(NUM_VC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [CLS_W-1:0]         wr_cls,
    input  logic [VC_W-1:0]          wr_vc,
    input  logic                     busy,
    output logic [NUM_CLS*VC_W-1:0]  map_flat
);

    logic [VC_W-1:0]  map_q [NUM_CLS];
    tbl_state_e       state_q;
    logic [CLS_W-1:0] pend_cls;
    logic [VC_W-1:0]  pend_vc;
    logic [CLS_W-1:0] eff_cls;
    logic [VC_W-1:0]  eff_vc;
    logic             apply;

    always_comb begin
        eff_cls = wr ? wr_cls : pend_cls;
        eff_vc  = wr ? wr_vc  : pend_vc;
        apply   = !busy && (wr || state_q == TBL_PENDING);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CLS; c++) map_q[c] <= VC_W'(c % NUM_VC);
            state_q  <= TBL_IDLE;
            pend_cls <= '0;
            pend_vc  <= '0;
        end else if (apply) begin
            map_q[eff_cls] <= eff_vc;
            state_q        <= TBL_IDLE;
        end else if (wr) begin
            pend_cls <= wr_cls;
            pend_vc  <= wr_vc;
            state_q  <= TBL_PENDING;
        end
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_flat
        assign map_flat[c*VC_W +: VC_W] = map_q[c];
    end

endmodule

// File: rtl/cg_credit_pool.sv
module cg_credit_pool
    import cg_pkg::*;
#(
    parameter int CRED_W = CG_CRED_W,
    parameter int LEN_W  = CG_LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [LEN_W-1:0]  take_len,
    input  logic              give,
    input  logic [CRED_W-1:0] give_amt,
    output logic [CRED_W-1:0] level,
    output logic              ovf
);

    logic [CRED_W:0] sum;

    always_comb begin
        sum = {1'b0, level};
        if (take) sum = sum - {{(CRED_W+1-LEN_W){1'b0}}, take_len};
        if (give) sum = sum + {1'b0, give_amt};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            ovf   <= 1'b0;
        end else if (sum[CRED_W]) begin
            level <= '1;
            ovf   <= 1'b1;
        end else begin
            level <= sum[CRED_W-1:0];
        end
    end

endmodule

// File: rtl/cg_rr_arb.sv
module cg_rr_arb
    import cg_pkg::*;
#(
    parameter int NUM_VC = CG_CHANNELS,
    localparam int VC_W  = $clog2(NUM_VC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_VC-1:0] elig,
    output logic              pick_vld,
    output logic [VC_W-1:0]   pick
);

    logic [VC_W-1:0] last_q;
    int              sel;

    always_comb begin
        sel      = rr_first({{(CG_MAX_CH-NUM_VC){1'b0}}, elig}, int'(last_q), NUM_VC);
        pick_vld = (sel >= 0);
        pick     = pick_vld ? VC_W'(sel) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)           last_q <= VC_W'(NUM_VC - 1);
        else if (pick_vld) last_q <= pick;
    end

endmodule

// File: rtl/cg_credit_gate.sv
module cg_credit_gate
    import cg_pkg::*;
#(
    parameter int NUM_CLS = CG_CLASSES,
    parameter int NUM_VC  = CG_CHANNELS,
    parameter int CRED_W  = CG_CRED_W,
    parameter int LEN_W   = CG_LEN_W,
    localparam int CLS_W  = $clog2(NUM_CLS),
    localparam int VC_W   = $clog2(NUM_VC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CLS-1:0]        cls_req,
    input  logic [NUM_CLS*LEN_W-1:0]  cls_len,
    input  logic                      ret_vld,
    input  logic [VC_W-1:0]           ret_vc,
    input  logic [CRED_W-1:0]         ret_amt,
    input  logic                      map_wr,
    input  logic [CLS_W-1:0]          map_wr_cls,
    input  logic [VC_W-1:0]           map_wr_vc,
    output logic                      gnt_vld,
    output logic [CLS_W-1:0]          gnt_cls,
    output logic [VC_W-1:0]           gnt_vc,
    output logic [NUM_VC*CRED_W-1:0]  cred_lvl,
    output logic [NUM_VC-1:0]         cred_ovf
);

    logic [NUM_CLS*VC_W-1:0] map_flat;
    logic [CRED_W-1:0]       lvl    [NUM_VC];
    logic [VC_W-1:0]         cls_vc [NUM_CLS];
    logic [LEN_W-1:0]        cls_ln [NUM_CLS];
    logic [NUM_CLS-1:0]      cls_ok;
    logic [NUM_VC-1:0]       vc_elig;
    logic [CLS_W-1:0]        vc_cls [NUM_VC];
    logic [LEN_W-1:0]        gnt_len;

    cg_map_table #(.NUM_CLS(NUM_CLS), .NUM_VC(NUM_VC)) u_table (
        .clk(clk), .rst(rst), .wr(map_wr), .wr_cls(map_wr_cls), .wr_vc(map_wr_vc),
        .busy(gnt_vld), .map_flat(map_flat)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign cls_vc[c] = map_flat[c*VC_W +: VC_W];
        assign cls_ln[c] = cls_len[c*LEN_W +: LEN_W];
        assign cls_ok[c] = cls_req[c] &&
                           (lvl[cls_vc[c]] >= {{(CRED_W-LEN_W){1'b0}}, cls_ln[c]});
    end

    // Per channel: any eligible member, and the lowest-numbered one.
    always_comb begin
        for (int v = 0; v < NUM_VC; v++) begin
            vc_elig[v] = 1'b0;
            vc_cls[v]  = '0;
            for (int c = NUM_CLS - 1; c >= 0; c--) begin
                if (cls_ok[c] && cls_vc[c] == VC_W'(v)) begin
                    vc_elig[v] = 1'b1;
                    vc_cls[v]  = CLS_W'(c);
                end
            end
        end
    end

    cg_rr_arb #(.NUM_VC(NUM_VC)) u_arb (
        .clk(clk), .rst(rst), .elig(vc_elig), .pick_vld(gnt_vld), .pick(gnt_vc)
    );

    assign gnt_cls = vc_cls[gnt_vc];
    assign gnt_len = cls_ln[gnt_cls];

    for (genvar v = 0; v < NUM_VC; v++) begin : g_pool
        cg_credit_pool #(.CRED_W(CRED_W), .LEN_W(LEN_W)) u_pool (
            .clk(clk), .rst(rst),
            .take(gnt_vld && gnt_vc == VC_W'(v)), .take_len(gnt_len),
            .give(ret_vld && ret_vc == VC_W'(v)), .give_amt(ret_amt),
            .level(lvl[v]), .ovf(cred_ovf[v])
        );
        assign cred_lvl[v*CRED_W +: CRED_W] = lvl[v];
    end

endmodule

// File: rtl/cg_credit_gate_chk.sv
module cg_credit_gate_chk #(
    parameter int NUM_CLS = 8,
    parameter int NUM_VC  = 4,
    parameter int CRED_W  = 12,
    parameter int LEN_W   = 7,
    localparam int CLS_W  = $clog2(NUM_CLS),
    localparam int VC_W   = $clog2(NUM_VC)
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_CLS-1:0]        cls_req,
    input logic [NUM_CLS*LEN_W-1:0]  cls_len,
    input logic                      ret_vld,
    input logic                      gnt_vld,
    input logic [CLS_W-1:0]          gnt_cls,
    input logic [VC_W-1:0]           gnt_vc,
    input logic [NUM_VC*CRED_W-1:0]  cred_lvl,
    input logic [NUM_VC-1:0]         cred_ovf,
    input logic [NUM_CLS*VC_W-1:0]   map_flat
);

    logic              any_fit;
    logic [LEN_W-1:0]  g_len;
    logic [CRED_W-1:0] g_lvl;
    logic              lst_chk;
    logic [VC_W-1:0]   lst_vc;
    logic [CRED_W-1:0] lst_exp;

    always_comb begin
        any_fit = 1'b0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (cls_req[c] &&
                cred_lvl[int'(map_flat[c*VC_W +: VC_W])*CRED_W +: CRED_W] >=
                {{(CRED_W-LEN_W){1'b0}}, cls_len[c*LEN_W +: LEN_W]})
                any_fit = 1'b1;
        end
        g_len = cls_len[int'(gnt_cls)*LEN_W +: LEN_W];
        g_lvl = cred_lvl[int'(gnt_vc)*CRED_W +: CRED_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lst_chk <= 1'b0;
            lst_vc  <= '0;
            lst_exp <= '0;
        end else begin
            lst_chk <= gnt_vld && !ret_vld;
            lst_vc  <= gnt_vc;
            lst_exp <= g_lvl - {{(CRED_W-LEN_W){1'b0}}, g_len};
        end
    end

    p_grant_fits_r2: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> (cls_req[gnt_cls] && g_lvl >= {{(CRED_W-LEN_W){1'b0}}, g_len}
                     && map_flat[int'(gnt_cls)*VC_W +: VC_W] == gnt_vc));

    p_no_req_no_grant_r2: assert property (@(posedge clk) disable iff (rst)
        !(|cls_req) |-> !gnt_vld);

    p_debit_r3: assert property (@(posedge clk) disable iff (rst)
        lst_chk |-> cred_lvl[int'(lst_vc)*CRED_W +: CRED_W] == lst_exp);

    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cred_ovf & $past(cred_ovf)) == $past(cred_ovf)));

    p_work_conserving_r9: assert property (@(posedge clk) disable iff (rst)
        any_fit |-> gnt_vld);

endmodule

bind cg_credit_gate cg_credit_gate_chk #(
    .NUM_CLS(NUM_CLS), .NUM_VC(NUM_VC), .CRED_W(CRED_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst(rst), .cls_req(cls_req), .cls_len(cls_len), .ret_vld(ret_vld),
    .gnt_vld(gnt_vld), .gnt_cls(gnt_cls), .gnt_vc(gnt_vc), .cred_lvl(cred_lvl),
    .cred_ovf(cred_ovf), .map_flat(map_flat)
);

// File: tb/cg_credit_gate_bench.sv
`timescale 1ns/1ps
module cg_credit_gate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cls_req;
    logic [55:0] cls_len;
    logic        ret_vld;
    logic [1:0]  ret_vc;
    logic [11:0] ret_amt;
    logic        map_wr;
    logic [2:0]  map_wr_cls;
    logic [1:0]  map_wr_vc;
    logic        gnt_vld;
    logic [2:0]  gnt_cls;
    logic [1:0]  gnt_vc;
    logic [47:0] cred_lvl;
    logic [3:0]  cred_ovf;

    logic [6:0]  b_len [8];
    int n_chk = 0;
    int n_err = 0;

    int m_map [8];
    int m_cred [4];
    int m_ovf [4];
    int m_last;
    bit pend_v;
    int pend_cls, pend_vc;
    int seed = 32'h1234567;

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < 8; c++) cls_len[c*7 +: 7] = b_len[c];
    end

    cg_credit_gate u_cg_credit_gate (
        .clk(clk), .rst(rst), .cls_req(cls_req), .cls_len(cls_len),
        .ret_vld(ret_vld), .ret_vc(ret_vc), .ret_amt(ret_amt),
        .map_wr(map_wr), .map_wr_cls(map_wr_cls), .map_wr_vc(map_wr_vc),
        .gnt_vld(gnt_vld), .gnt_cls(gnt_cls), .gnt_vc(gnt_vc),
        .cred_lvl(cred_lvl), .cred_ovf(cred_ovf)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected grant from the requirements: round-robin channel, lowest class in it.
    task automatic model_gnt(output bit v, output int cls, output int vc);
        v = 0; cls = 0; vc = 0;
        for (int i = 1; i <= 4; i++) begin
            int ch;
            ch = (m_last + i) % 4;
            for (int c = 0; c < 8; c++) begin
                if (!v && cls_req[c] && m_map[c] == ch && m_cred[ch] >= int'(b_len[c])) begin
                    v = 1; cls = c; vc = ch;
                end
            end
        end
    endtask

    // Called at a falling edge with inputs set; checks, crosses one rising edge.
    task automatic step(input string tag);
        bit ev; int ec, evc, ecls, evv;
        #1;
        model_gnt(ev, ec, evc);
        chk(gnt_vld == ev, tag, "gnt_vld", int'(gnt_vld), int'(ev));
        if (ev && gnt_vld) begin
            chk(int'(gnt_cls) == ec, tag, "gnt_cls", int'(gnt_cls), ec);
            chk(int'(gnt_vc) == evc, tag, "gnt_vc", int'(gnt_vc), evc);
        end
        for (int v = 0; v < 4; v++) begin
            chk(int'(cred_lvl[v*12 +: 12]) == m_cred[v], tag, "cred_lvl",
                int'(cred_lvl[v*12 +: 12]), m_cred[v]);
            chk(int'(cred_ovf[v]) == m_ovf[v], tag, "cred_ovf", int'(cred_ovf[v]), m_ovf[v]);
        end
        @(posedge clk);
        for (int v = 0; v < 4; v++) begin
            int n;
            n = m_cred[v];
            if (ev && evc == v) n = n - int'(b_len[ec]);
            if (ret_vld && int'(ret_vc) == v) n = n + int'(ret_amt);
            if (n > 4095) begin n = 4095; m_ovf[v] = 1; end
            m_cred[v] = n;
        end
        ecls = map_wr ? int'(map_wr_cls) : pend_cls;
        evv  = map_wr ? int'(map_wr_vc)  : pend_vc;
        if (!ev && (map_wr || pend_v)) begin
            m_map[ecls] = evv; pend_v = 0;
        end else if (map_wr) begin
            pend_v = 1; pend_cls = ecls; pend_vc = evv;
        end
        if (ev) m_last = evc;
        @(negedge clk);
        ret_vld = 0; map_wr = 0;
    endtask

    task automatic give(input int vc, input int amt, input string tag);
        ret_vld = 1; ret_vc = 2'(vc); ret_amt = 12'(amt);
        step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        cls_req = 0; ret_vld = 0; ret_vc = 0; ret_amt = 0;
        map_wr = 0; map_wr_cls = 0; map_wr_vc = 0;
        for (int c = 0; c < 8; c++) begin b_len[c] = 7'd1; m_map[c] = c % 4; end
        for (int v = 0; v < 4; v++) begin m_cred[v] = 0; m_ovf[v] = 0; end
        m_last = 3; pend_v = 0; pend_cls = 0; pend_vc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state, then a request with no credit must wait
        step("R1");
        cls_req = 8'h01; step("R5");
        cls_req = 0;

        // R3: fill each channel
        for (int v = 0; v < 4; v++) give(v, 100, "R3");

        // R1: default mapping, one class at a time
        for (int c = 0; c < 8; c++) begin
            cls_req = 8'(1 << c); b_len[c] = 7'd5; step("R1");
        end
        cls_req = 0; step("R3");

        // R2/R5: lengths around the credit level; a neighbour on another channel
        for (int v = 0; v < 4; v++) begin
            for (int d = -1; d <= 1; d++) begin
                int nb;
                nb = (v + 1) % 4;
                b_len[v]  = 7'(m_cred[v] + d);
                b_len[nb] = 7'd1;
                cls_req = 8'((1 << v) | (1 << nb));
                step("R5");
                cls_req = 0;
                step("R2");
                for (int k = 0; k < 4; k++) if (m_cred[k] < 100) give(k, 100 - m_cred[k], "R3");
            end
        end

        // R6/R7: every class asks, lengths 1
        for (int c = 0; c < 8; c++) b_len[c] = 7'd1;
        cls_req = 8'hFF;
        for (int i = 0; i < 10; i++) step("R6");
        cls_req = 8'h11; step("R7"); step("R7");
        cls_req = 0;

        // R3: grant and return on the same channel in one cycle
        cls_req = 8'h04; b_len[2] = 7'd7;
        ret_vld = 1; ret_vc = 2'd2; ret_amt = 12'd3; step("R3");
        cls_req = 0; step("R3");

        // R8: write held while grants continue, replaced, then applied when idle
        cls_req = 8'h03; b_len[0] = 7'd1; b_len[1] = 7'd1;
        map_wr = 1; map_wr_cls = 3'd0; map_wr_vc = 2'd3; step("R8");
        step("R8");
        map_wr = 1; map_wr_cls = 3'd0; map_wr_vc = 2'd2; step("R8");
        cls_req = 0; step("R8");
        cls_req = 8'h01; step("R8");
        step("R8");
        map_wr = 1; map_wr_cls = 3'd0; map_wr_vc = 2'd0; cls_req = 0; step("R8");
        cls_req = 8'h01; step("R8");
        cls_req = 0;

        // R4: saturation and sticky flag
        give(2, 4095, "R4");
        give(2, 4095, "R4");
        cls_req = 8'h04; b_len[2] = 7'd100; step("R4");
        cls_req = 0; step("R4");
        step("R4");

        // R9: pseudo-random mix of requests, lengths and returns
        for (int i = 0; i < 300; i++) begin
            seed = seed * 1103515245 + 12345;
            cls_req = 8'(seed >> 8);
            for (int c = 0; c < 8; c++) b_len[c] = 7'(1 + ((seed >> (c * 3)) & 7));
            ret_vld = ((seed >> 20) & 1) == 1;
            ret_vc = 2'((seed >> 22) & 3);
            ret_amt = 12'((seed >> 24) & 15);
            if ((i % 37) == 5) begin
                map_wr = 1; map_wr_cls = 3'((seed >> 4) & 7); map_wr_vc = 2'((seed >> 13) & 3);
            end
            step("R9");
        end
        cls_req = 0; step("R9");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule